// File: doc/BRIEF.md
# General-Purpose Event Register Block

This block holds a small bank of general-purpose event flags together with a matching bank of per-flag enables, and reports them to the interrupt fabric as one system control interrupt line. Hardware sources pulse their event inputs. Each pulse latches a sticky status flag. Software reads the flags through a byte-lane I/O slave port and acknowledges each flag by writing a one to it. The interrupt output is a level signal. It stays high while at least one latched flag has its enable set.

The block decodes its own four-byte window at I/O address 0xAFE0. Each access carries a dword address and four byte enables. Every enabled lane is handled as a separate byte operation, so 1-, 2- and 4-byte accesses all behave the same way byte for byte. The window holds the status half in its lower bytes and the enable half in its upper bytes, in little-endian order. A fixed output reports the interrupt line number that software should use.

Top module: `gpe0_block`

## Requirements
- R1: An access hits only when io_addr[15:2] equals 0xAFE0 >> 2, and io_addr[1:0] is ignored. A write that misses changes nothing. A read that misses returns zero on every lane.
- R2: Lane k (io_be[k], io_wdata/io_rdata bits 8k+7..8k) maps to window offset k in little-endian order. Offset 0 is status[7:0], offset 1 is status[15:8], offset 2 is enable[7:0] and offset 3 is enable[15:8]. Each enabled lane is an independent byte operation. A lane whose enable is low is not written, and it reads as zero.
- R3: Writing a one to a status bit clears it. Writing a zero leaves it unchanged.
- R4: When evt_in[i] is high at a clock edge, status bit i is set at that edge. If the same edge also carries a clearing write to bit i, the event wins and the bit stays set.
- R5: Enable bits are plain read/write storage. A written enable byte takes the written value.
- R6: sci is active high and equals the OR over all i of (status[i] AND enable[i]). It reflects the registers updated at an edge in the cycle that follows that edge, with no extra delay.
- R7: Synchronous reset clears every status and enable bit, so sci is low after reset.
- R8: io_rdata is registered. On the edge where io_rd is sampled, it loads the values the registers held before that edge. In every cycle that follows an edge without io_rd, it reads zero.
- R9: sci_line always reports interrupt number 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O dword address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_be | input | 4 | Byte-lane enables |
| io_wdata | input | 32 | Write data, lane k in bits 8k+7..8k |
| io_rdata | output | 32 | Registered read data |
| evt_in | input | 16 | Event inputs, one per status bit |
| sci | output | 1 | Level interrupt request |
| sci_line | output | 8 | Interrupt number reported to software |

## Verification
A write or an event changes the status and enable registers at the edge where it is sampled. sci follows those registers in the same cycle, so sci is due one edge after the stimulus. Read data is due one edge after the read strobe and falls back to zero after the next edge. The bench drives every stimulus on a falling edge and samples both results on the next falling edge, half a period after the edge that produced them. The sweeps cover every status bit, every byte-enable pattern, every status/enable pairing for sci, and a spread of hitting and missing addresses.

// File: rtl/gpe0_pkg.sv
package gpe0_pkg;

    localparam int LANE_W = 8;

    // One byte-lane operation after window decode.
    typedef struct packed {
        logic                wr;
        logic                rd;
        logic [LANE_W-1:0]   data;
    } lane_op_t;

    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_ENABLE = 1'b1
    } region_e;

    // Lower half of the window is status, upper half is enable.
    function automatic region_e lane_region(input int lane, input int half_bytes);
        return (lane < half_bytes) ? REG_STATUS : REG_ENABLE;
    endfunction

    // Byte index inside the register that a lane addresses.
    function automatic int lane_reg_byte(input int lane, input int half_bytes);
        return (lane < half_bytes) ? lane : lane - half_bytes;
    endfunction

endpackage

// File: rtl/gpe0_decode.sv
module gpe0_decode
    import gpe0_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hAFE0,
    parameter int               WIN_BYTES = 4,
    localparam int              OFS_W     = $clog2(WIN_BYTES),
    localparam int              BUS_W     = WIN_BYTES * LANE_W
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr,
    input  logic                      rd,
    input  logic [WIN_BYTES-1:0]      be,
    input  logic [BUS_W-1:0]          wdata,
    output logic                      hit,
    output lane_op_t [WIN_BYTES-1:0]  ops
);

    assign hit = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);

    for (genvar k = 0; k < WIN_BYTES; k++) begin : g_lane
        assign ops[k].wr   = wr & hit & be[k];
        assign ops[k].rd   = rd & hit & be[k];
        assign ops[k].data = wdata[k*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/gpe0_status_bank.sv
module gpe0_status_bank
    import gpe0_pkg::*;
#(
    parameter int  NBYTES = 2,
    localparam int NBITS  = NBYTES * LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  lane_op_t [NBYTES-1:0]   ops,
    input  logic [NBITS-1:0]        evt,
    output logic [NBITS-1:0]        sts_q
);

    logic [NBITS-1:0] clr_vec;
    logic [NBITS-1:0] sts_d;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign clr_vec[b*LANE_W +: LANE_W] = ops[b].wr ? ops[b].data : '0;
    end

    // Event has priority over acknowledge.
    assign sts_d = evt | (sts_q & ~clr_vec);

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= sts_d;
    end

    // R3: acknowledged bits without a concurrent event are cleared
    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0) |=> ((sts_q & $past(clr_vec & ~evt)) == '0));

    // R4: every pulsed event bit is set at the next edge
    p_event_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((sts_q & $past(evt)) == $past(evt)));

    // R3: bits that were neither set nor cleared hold their value
    p_untouched_hold_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sts_q & ~$past(evt | clr_vec)) ==
                  ($past(sts_q) & ~$past(evt | clr_vec))));

endmodule

// File: rtl/gpe0_enable_bank.sv
module gpe0_enable_bank
    import gpe0_pkg::*;
#(
    parameter int  NBYTES = 2,
    localparam int NBITS  = NBYTES * LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  lane_op_t [NBYTES-1:0]   ops,
    output logic [NBITS-1:0]        en_q
);

    logic [NBITS-1:0] en_d;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign en_d[b*LANE_W +: LANE_W] = ops[b].wr ? ops[b].data
                                                    : en_q[b*LANE_W +: LANE_W];

        // R5: a written enable byte holds the written value
        p_en_write_r5: assert property (@(posedge clk) disable iff (rst)
            ops[b].wr |=> (en_q[b*LANE_W +: LANE_W] == $past(ops[b].data)));
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

endmodule

// File: rtl/gpe0_block.sv
module gpe0_block
    import gpe0_pkg::*;
#(
    parameter int               ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR    = 16'hAFE0,
    parameter int               GPE_BYTES    = 2,
    parameter logic [7:0]       SCI_LINE_NUM = 8'd9,
    localparam int              WIN_BYTES    = 2 * GPE_BYTES,
    localparam int              EVT_W        = GPE_BYTES * LANE_W,
    localparam int              BUS_W        = WIN_BYTES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [WIN_BYTES-1:0] io_be,
    input  logic [BUS_W-1:0]     io_wdata,
    output logic [BUS_W-1:0]     io_rdata,
    input  logic [EVT_W-1:0]     evt_in,
    output logic                 sci,
    output logic [7:0]           sci_line
);

    lane_op_t [WIN_BYTES-1:0] ops;
    lane_op_t [GPE_BYTES-1:0] sts_ops;
    lane_op_t [GPE_BYTES-1:0] en_ops;
    logic                     hit;
    logic [EVT_W-1:0]         sts_q;
    logic [EVT_W-1:0]         en_q;
    logic [BUS_W-1:0]         rdata_d;

    gpe0_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .WIN_BYTES (WIN_BYTES)
    ) i_decode (
        .addr  (io_addr),
        .wr    (io_wr),
        .rd    (io_rd),
        .be    (io_be),
        .wdata (io_wdata),
        .hit   (hit),
        .ops   (ops)
    );

    // Route lanes to the two register halves and build read data.
    for (genvar k = 0; k < WIN_BYTES; k++) begin : g_route
        localparam int RB = lane_reg_byte(k, GPE_BYTES);
        if (lane_region(k, GPE_BYTES) == REG_STATUS) begin : g_sts
            assign sts_ops[RB] = ops[k];
            assign rdata_d[k*LANE_W +: LANE_W] =
                ops[k].rd ? sts_q[RB*LANE_W +: LANE_W] : '0;
        end else begin : g_en
            assign en_ops[RB] = ops[k];
            assign rdata_d[k*LANE_W +: LANE_W] =
                ops[k].rd ? en_q[RB*LANE_W +: LANE_W] : '0;
        end
    end

    gpe0_status_bank #(.NBYTES(GPE_BYTES)) i_status (
        .clk   (clk),
        .rst   (rst),
        .ops   (sts_ops),
        .evt   (evt_in),
        .sts_q (sts_q)
    );

    gpe0_enable_bank #(.NBYTES(GPE_BYTES)) i_enable (
        .clk  (clk),
        .rst  (rst),
        .ops  (en_ops),
        .en_q (en_q)
    );

    always_ff @(posedge clk) begin
        if (rst) io_rdata <= '0;
        else     io_rdata <= rdata_d;
    end

    assign sci      = |(sts_q & en_q);
    assign sci_line = SCI_LINE_NUM;

    // R1: a read outside the window returns zero
    p_miss_read_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !hit) |=> (io_rdata == '0));

    // R1: a write outside the window changes no register
    p_miss_write_none_r1: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !hit && evt_in == '0) |=> ($stable(en_q) && $stable(sts_q)));

    // R6: no enable set means no interrupt
    p_sci_off_r6: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !sci);

    // R7: registers are clear after a reset cycle
    p_reset_clear_r7: assert property (@(posedge clk)
        $past(rst) |-> (sts_q == '0 && en_q == '0 && !sci));

    // R8: read data returns to zero after an idle edge
    p_rdata_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> (io_rdata == '0));

endmodule

// File: tb/test_gpe0_block.sv
module test_gpe0_block;

    localparam logic [15:0] BASE = 16'hAFE0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic [15:0] evt_in = '0;
    logic        sci;
    logic [7:0]  sci_line;

    int checks = 0;
    int fails  = 0;
    logic [15:0] m_sts = '0;
    logic [15:0] m_en  = '0;

    always #4 clk = ~clk;

    gpe0_block i_gpe0_block (
        .clk      (clk),
        .rst      (rst),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_be    (io_be),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .evt_in   (evt_in),
        .sci      (sci),
        .sci_line (sci_line)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic in_win(input logic [15:0] a);
        return a[15:2] == BASE[15:2];
    endfunction

    // Write with an optional concurrent event; the model clears first, then sets.
    task automatic wr(input logic [15:0] a, input logic [3:0] be,
                      input logic [31:0] d, input logic [15:0] ev);
        @(negedge clk);
        io_addr = a; io_be = be; io_wdata = d; io_wr = 1'b1; evt_in = ev;
        @(negedge clk);
        io_wr = 1'b0; io_be = '0; evt_in = '0;
        if (in_win(a)) begin
            for (int k = 0; k < 4; k++) begin
                if (be[k]) begin
                    if (k < 2) m_sts[k*8 +: 8] = m_sts[k*8 +: 8] & ~d[k*8 +: 8];
                    else       m_en[(k-2)*8 +: 8] = d[k*8 +: 8];
                end
            end
        end
        m_sts = m_sts | ev;
    endtask

    task automatic pulse(input logic [15:0] ev);
        @(negedge clk);
        evt_in = ev;
        @(negedge clk);
        evt_in = '0;
        m_sts = m_sts | ev;
    endtask

    task automatic rd(input logic [15:0] a, input logic [3:0] be, output logic [31:0] v);
        @(negedge clk);
        io_addr = a; io_be = be; io_rd = 1'b1;
        @(negedge clk);
        v = io_rdata;
        io_rd = 1'b0; io_be = '0;
    endtask

    function automatic logic [31:0] exp_rd(input logic [15:0] a, input logic [3:0] be);
        logic [31:0] full;
        logic [31:0] r;
        full = {m_en, m_sts};
        r = '0;
        if (in_win(a))
            for (int k = 0; k < 4; k++)
                if (be[k]) r[k*8 +: 8] = full[k*8 +: 8];
        return r;
    endfunction

    task automatic chk_all(input string req);
        logic [31:0] v;
        rd(BASE, 4'hF, v);
        chk(req, v, {m_en, m_sts});
        chk({req, " R6 sci"}, {31'b0, sci}, {31'b0, |(m_sts & m_en)});
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7: reset state; R9: interrupt number
        chk_all("R7 reset");
        chk("R7 sci after reset", {31'b0, sci}, 32'd0);
        chk("R9 sci_line", {24'b0, sci_line}, 32'd9);

        // R4 and R3: every status bit set by event, then acknowledged
        for (int i = 0; i < 16; i++) begin
            pulse(16'(1 << i));
            rd(BASE, 4'h3, v);
            chk("R4 event sets bit", v, exp_rd(BASE, 4'h3));
            wr(BASE, 4'h3, 32'h0000_0000, '0);   // writing zeros: no effect
            chk_all("R3 zero write keeps");
            wr(BASE, 4'(1 << (i / 8)), 32'(1 << i), '0);
            chk_all("R3 w1c clears");
        end

        // R3: partial acknowledge leaves other bits
        pulse(16'hF0F0);
        wr(BASE, 4'h3, 32'h0000_3030, '0);
        chk_all("R3 partial ack");
        wr(BASE, 4'h3, 32'h0000_FFFF, '0);

        // R4: event wins over same-cycle acknowledge
        pulse(16'h0018);
        wr(BASE, 4'h1, 32'h0000_0018, 16'h0008);
        chk_all("R4 event beats clear");
        chk("R4 bit3 kept", {31'b0, m_sts[3]}, 32'd1);
        wr(BASE, 4'h3, 32'h0000_FFFF, '0);

        // R2 and R5: every byte-enable pattern, read back with every pattern
        for (int b = 0; b < 16; b++) begin
            pulse(16'h5AC3);
            wr(BASE, 4'(b), {4'(b), 4'h9, 4'hE ^ 4'(b), 4'h1, 16'hA50F}, '0);
            chk_all("R5 enable rw / R2 lanes");
            for (int r = 0; r < 16; r++) begin
                rd(BASE + 16'(r % 4), 4'(r), v);
                chk("R2 lane read", v, exp_rd(BASE, 4'(r)));
            end
        end

        // R6: every status/enable pairing
        for (int j = 0; j < 16; j++) begin
            wr(BASE, 4'hC, 32'(1 << j) << 16, '0);
            for (int i = 0; i < 16; i++) begin
                wr(BASE, 4'h3, 32'h0000_FFFF, 16'(1 << i));
                chk("R6 sci pair", {31'b0, sci}, {31'b0, (i == j)});
                wr(BASE, 4'h3, 32'h0000_FFFF, '0);
                chk("R6 sci after ack", {31'b0, sci}, 32'd0);
            end
        end
        wr(BASE, 4'hC, 32'h0, '0);

        // R1: address decode
        begin
            logic [15:0] addrs [8] = '{16'hAFE0, 16'hAFE1, 16'hAFE3, 16'hAFDC,
                                       16'hAFE4, 16'h2FE0, 16'h0000, 16'hEFE0};
            for (int n = 0; n < 8; n++) begin
                wr(BASE, 4'hC, 32'h0, '0);
                wr(addrs[n], 4'hC, 32'h1234_0000, '0);
                chk_all("R1 write decode");
                pulse(16'h0101);
                wr(addrs[n], 4'h3, 32'h0000_0001, '0);
                chk_all("R1 ack decode");
                rd(addrs[n], 4'hF, v);
                chk("R1 read decode", v, exp_rd(addrs[n], 4'hF));
            end
        end

        // R8: read data falls back to zero; read returns pre-edge value
        pulse(16'h0042);
        rd(BASE, 4'hF, v);
        @(negedge clk);
        chk("R8 idle rdata zero", io_rdata, 32'h0);
        @(negedge clk);
        io_addr = BASE; io_be = 4'h1; io_rd = 1'b1; io_wr = 1'b1; io_wdata = 32'h0000_0002;
        @(negedge clk);
        chk("R8 pre-edge read", io_rdata, {24'h0, m_sts[7:0]});
        io_rd = 1'b0; io_wr = 1'b0; io_be = '0;
        m_sts[1] = 1'b0;
        chk_all("R8 write after read");

        // R7: reset in mid-operation
        wr(BASE, 4'hF, 32'hFFFF_0000, 16'hFFFF);
        chk("R6 sci high before reset", {31'b0, sci}, 32'd1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_sts = '0; m_en = '0;
        chk_all("R7 mid reset");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule